// File: doc/BRIEF.md
# Error-Feedback Digital Delta-Sigma Encoder

This block turns a stream of signed PCM words, already at eight times the Nyquist rate, into a one-bit bitstream. It is a second-order modulator built entirely from digital logic. The quantizer is the sign bit of an internal sum. The low-order bits of that sum, with one bit inverted, serve directly as the quantization error. That error goes through a second-order recursive loop filter and is added to the next input word. All loop coefficients are sums of power-of-two shifts, so the block has no multipliers.

The signal passes through with unity gain. The noise transfer function has a double zero pair on the unit circle, placed away from zero frequency so that most of the noise leaves the low band at this small oversampling ratio. A new PCM word is accepted on every rising clock edge. One output bit leaves per clock, and downstream bitstream logic consumes it directly.

Top module: `ef_dsm_encoder`

## Requirements
- R1: An active-low asynchronous reset forces bit_o to 0 and clears the input register and all loop history to zero. After release, the bitstream is identical to the one produced from power-up for the same input sequence.
- R2: pcm_i is sampled on every rising clock edge. The bit decided from that sample appears on bit_o at the next rising edge. The first bit after reset release is 1, because the zero-cleared sum counts as non-negative.
- R3: The quantizer input is the registered sample scaled by 2^FRAC_W plus the loop feedback. bit_o = 1 (meaning +FS, with FS = 2^(IN_W-1) input LSBs) when that input is ≥ 0, and bit_o = 0 (meaning −FS) otherwise.
- R4: The quantization error equals the quantizer input minus the chosen level (±FS·2^FRAC_W). It is taken by inverting bit IN_W−1+FRAC_W of the sum and keeping the bits below it, so it always lies in [−FS·2^FRAC_W, FS·2^FRAC_W).
- R5: Before quantizing, the sum is clamped to [−2FS·2^FRAC_W, 2FS·2^FRAC_W − 1]. A sum above that range yields bit 1 with the largest positive error. A sum below it yields bit 0 with the most negative error.
- R6: The feedback follows f[n+1] = A1(f[n]) − A2(f[n−1]) + B1(e[n]) − B2(e[n−1]), with all state zero after reset. The coefficients are A1 = 1 + 2^-3 + 2^-4 + 2^-6, A2 = 2^-1 − 2^-4 − 2^-7, B1 = 2^-1 + 2^-2 − 2^-8 and B2 = 2^-1 + 2^-4 + 2^-7. Each term is its own arithmetic right shift (rounding toward −∞) carrying the sign shown, and the default FRAC_W is 8.
- R7: For a constant input x with |x| ≤ 0.4·FS, the clamp never engages. The mean of the ±FS output levels over 512 consecutive bits then lies within 0.3·FS of x, so the signal gain is unity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at the oversampled rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pcm_i | input | IN_W (10) | Signed two's-complement PCM sample, one per clock |
| bit_o | output | 1 | Encoded bitstream, 1 = +full scale, 0 = −full scale |

## Verification
A corrupted loop state does not stay hidden. Every feedback value feeds the very next quantizer decision. A wrong coefficient term, a wrong error bit or a missing clamp therefore flips some output bit within a few clocks of a stimulus that exercises it. The bench compares every output bit against an arithmetic model across a sweep of every input code, alternating, ramped and pseudo-random inputs, and full-scale overload. It also measures the long-run average of the stream for mid-range constants, which exposes a gain or sign error that a single bit might not show.

// File: rtl/dsm_ef_pkg.sv
package dsm_ef_pkg;

   // Each loop coefficient is a sum of up to TERMS shifted copies of its operand.
   localparam int unsigned TERMS = 4;
   localparam int unsigned SH_W  = 4;
   localparam int unsigned MAX_SHIFT = 8;

   typedef logic [TERMS-1:0][SH_W-1:0] shift_tab_t;
   typedef logic [TERMS-1:0]           term_mask_t;

   // Pole path on f[n]: 1 + 1/8 + 1/16 + 1/64 (about 1.2031)
   localparam shift_tab_t P1_SH  = {4'd6, 4'd4, 4'd3, 4'd0};
   localparam term_mask_t P1_NEG = 4'b0000;
   localparam term_mask_t P1_USE = 4'b1111;

   // Pole path on f[n-1], sign folded in: -(1/2 - 1/16 - 1/128) (about -0.4297)
   localparam shift_tab_t P2_SH  = {4'd0, 4'd7, 4'd4, 4'd1};
   localparam term_mask_t P2_NEG = 4'b0001;
   localparam term_mask_t P2_USE = 4'b0111;

   // Zero path on e[n]: 1/2 + 1/4 - 1/256 (about 0.7461)
   localparam shift_tab_t Z1_SH  = {4'd0, 4'd8, 4'd2, 4'd1};
   localparam term_mask_t Z1_NEG = 4'b0100;
   localparam term_mask_t Z1_USE = 4'b0111;

   // Zero path on e[n-1], sign folded in: -(1/2 + 1/16 + 1/128) (about -0.5703)
   localparam shift_tab_t Z2_SH  = {4'd0, 4'd7, 4'd4, 4'd1};
   localparam term_mask_t Z2_NEG = 4'b0111;
   localparam term_mask_t Z2_USE = 4'b0111;

endpackage

// File: rtl/dsm_shift_add.sv
module dsm_shift_add
   import dsm_ef_pkg::*;
#(
   parameter int unsigned W   = 22,
   parameter shift_tab_t  SH  = '0,
   parameter term_mask_t  NEG = '0,
   parameter term_mask_t  USE = '0
) (
   input  logic signed [W-1:0] opd_i,
   output logic signed [W-1:0] prod_o
);

   logic signed [W-1:0] term [TERMS];

   for (genvar t = 0; t < TERMS; t++) begin : g_term
      if (USE[t]) begin : g_on
         if (NEG[t]) begin : g_sub
            assign term[t] = -(opd_i >>> SH[t]);
         end else begin : g_add
            assign term[t] = opd_i >>> SH[t];
         end
      end else begin : g_off
         assign term[t] = '0;
      end
   end

   always_comb begin
      prod_o = '0;
      for (int t = 0; t < TERMS; t++) begin
         prod_o = prod_o + term[t];
      end
   end

endmodule

// File: rtl/dsm_quantizer.sv
module dsm_quantizer #(
   parameter int unsigned IN_W   = 10,
   parameter int unsigned FRAC_W = 8,
   parameter int unsigned ACC_W  = 22
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic signed [ACC_W-1:0]         sum_i,
   output logic                            dec_o,
   output logic signed [IN_W+FRAC_W-1:0]   err_o
);

   localparam int unsigned CW = IN_W + FRAC_W + 1;
   localparam int unsigned EW = IN_W + FRAC_W;
   localparam longint LIM = longint'(1) <<< (CW - 1);
   localparam logic signed [ACC_W-1:0] HI = ACC_W'(LIM - 1);
   localparam logic signed [ACC_W-1:0] LO = ACC_W'(-LIM);
   localparam logic signed [ACC_W-1:0] LVL = ACC_W'(longint'(1) <<< (EW - 1));
   localparam logic signed [EW-1:0] ERR_MAX = {1'b0, {(EW-1){1'b1}}};
   localparam logic signed [EW-1:0] ERR_MIN = {1'b1, {(EW-1){1'b0}}};

   logic signed [CW-1:0] clip;
   logic                 sat;

   always_comb begin
      sat = 1'b0;
      if (sum_i > HI) begin
         clip = HI[CW-1:0];
         sat  = 1'b1;
      end else if (sum_i < LO) begin
         clip = LO[CW-1:0];
         sat  = 1'b1;
      end else begin
         clip = sum_i[CW-1:0];
      end
   end

   // Sign bit decides; the bits below it, top one inverted, are the error.
   assign dec_o = ~clip[CW-1];
   assign err_o = {~clip[CW-2], clip[CW-3:0]};

   p_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_o == (sum_i >= 0));

   p_err_recon_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sat |-> ((dec_o ? (ACC_W'(err_o) + LVL) : (ACC_W'(err_o) - LVL)) == sum_i));

   p_clamp_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_i > HI) |-> (dec_o && (err_o == ERR_MAX)));

   p_clamp_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_i < LO) |-> (!dec_o && (err_o == ERR_MIN)));

endmodule

// File: rtl/dsm_loop_filter.sv
module dsm_loop_filter
   import dsm_ef_pkg::*;
#(
   parameter int unsigned IN_W   = 10,
   parameter int unsigned FRAC_W = 8,
   parameter int unsigned ACC_W  = 22
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic signed [IN_W+FRAC_W-1:0] err_i,
   output logic signed [ACC_W-1:0]       fb_o
);

   localparam logic signed [ACC_W-1:0] BOUND =
      ACC_W'(longint'(1) <<< (IN_W + FRAC_W));

   logic signed [ACC_W-1:0] f_cur, f_prev, e_prev, err_x;
   logic signed [ACC_W-1:0] p1, p2, z1, z2, f_next;

   assign err_x = ACC_W'(err_i);

   dsm_shift_add #(.W(ACC_W), .SH(P1_SH), .NEG(P1_NEG), .USE(P1_USE))
      u_pole1 (.opd_i(f_cur),  .prod_o(p1));
   dsm_shift_add #(.W(ACC_W), .SH(P2_SH), .NEG(P2_NEG), .USE(P2_USE))
      u_pole2 (.opd_i(f_prev), .prod_o(p2));
   dsm_shift_add #(.W(ACC_W), .SH(Z1_SH), .NEG(Z1_NEG), .USE(Z1_USE))
      u_zero1 (.opd_i(err_x),  .prod_o(z1));
   dsm_shift_add #(.W(ACC_W), .SH(Z2_SH), .NEG(Z2_NEG), .USE(Z2_USE))
      u_zero2 (.opd_i(e_prev), .prod_o(z2));

   assign f_next = p1 + p2 + z1 + z2;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         f_cur  <= '0;
         f_prev <= '0;
         e_prev <= '0;
      end else begin
         f_cur  <= f_next;
         f_prev <= f_cur;
         e_prev <= err_x;
      end
   end

   assign fb_o = f_cur;

   p_state_clear_r1: assert property (@(posedge clk_i)
      !rst_ni |=> ((f_cur == '0) && (f_prev == '0) && (e_prev == '0)));

   // A stable loop with a bounded error keeps its feedback under two full scales.
   p_fb_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (f_cur < BOUND) && (f_cur > -BOUND));

endmodule

// File: rtl/ef_dsm_encoder.sv
module ef_dsm_encoder
   import dsm_ef_pkg::*;
#(
   parameter int unsigned IN_W    = 10,
   parameter int unsigned GUARD_W = 4,
   parameter int unsigned FRAC_W  = 8
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic signed [IN_W-1:0] pcm_i,
   output logic                   bit_o
);

   localparam int unsigned ACC_W = IN_W + GUARD_W + FRAC_W;
   localparam int unsigned EW    = IN_W + FRAC_W;

   if (IN_W < 7) begin : g_bad_in_w
      $error("ef_dsm_encoder: IN_W must be at least 7");
   end
   if (GUARD_W < 4) begin : g_bad_guard
      $error("ef_dsm_encoder: GUARD_W must be at least 4");
   end
   if (FRAC_W < MAX_SHIFT) begin : g_bad_frac
      $error("ef_dsm_encoder: FRAC_W must cover the finest coefficient shift");
   end

   logic signed [IN_W-1:0]  pcm_q;
   logic signed [ACC_W-1:0] fb, sum;
   logic signed [EW-1:0]    err;
   logic                    dec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pcm_q <= '0;
         bit_o <= 1'b0;
      end else begin
         pcm_q <= pcm_i;
         bit_o <= dec;
      end
   end

   assign sum = (ACC_W'(pcm_q) <<< FRAC_W) + fb;

   dsm_quantizer #(.IN_W(IN_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_quant (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sum_i (sum),
      .dec_o (dec),
      .err_o (err)
   );

   dsm_loop_filter #(.IN_W(IN_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_loop (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .err_i (err),
      .fb_o  (fb)
   );

   p_out_reset_r1: assert property (@(posedge clk_i)
      !rst_ni |=> !bit_o);

   p_first_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |=> bit_o);

endmodule

// File: tb/tb_ef_dsm_encoder.sv
module tb_ef_dsm_encoder;

   localparam int CLK_PERIOD = 10;
   localparam longint FSC = 512 * 256;   // full scale in loop units
   localparam longint LIM = 2 * FSC;

   logic              clk = 1'b0;
   logic              rst_n;
   logic signed [9:0] pcm;
   logic              bit_w;

   int checks = 0;
   int errors = 0;

   longint mx, mfc, mfp, mep;
   logic   mb;

   always #(CLK_PERIOD/2) clk = ~clk;

   ef_dsm_encoder dut (.clk_i(clk), .rst_ni(rst_n), .pcm_i(pcm), .bit_o(bit_w));

   function automatic longint a1(longint x);
      return x + (x >>> 3) + (x >>> 4) + (x >>> 6);
   endfunction
   function automatic longint na2(longint x);
      return -(x >>> 1) + (x >>> 4) + (x >>> 7);
   endfunction
   function automatic longint b1(longint x);
      return (x >>> 1) + (x >>> 2) - (x >>> 8);
   endfunction
   function automatic longint nb2(longint x);
      return -(x >>> 1) - (x >>> 4) - (x >>> 7);
   endfunction

   task automatic model_reset();
      mx = 0; mfc = 0; mfp = 0; mep = 0; mb = 1'b0;
   endtask

   task automatic model_step(input longint xin);
      longint v, q, e, fn;
      v = (mx * 256) + mfc;
      if (v > LIM - 1) v = LIM - 1;
      if (v < -LIM)    v = -LIM;
      mb = (v >= 0);
      q = mb ? FSC : -FSC;
      e = v - q;
      fn = a1(mfc) + na2(mfp) + b1(e) + nb2(mep);
      mfp = mfc;
      mfc = fn;
      mep = e;
      mx  = xin;
   endtask

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Entered and left at a falling edge.
   task automatic run_cycle(input int xin, input string req);
      pcm = xin[9:0];
      @(posedge clk);
      model_step(longint'(xin));
      @(negedge clk);
      check(req, longint'(bit_w), longint'(mb));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      check("R1 bit in reset", longint'(bit_w), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      rst_n = 1'b0;
      pcm   = '0;
      model_reset();
      @(negedge clk);
      do_reset();

      // R2: output follows the sample taken one edge earlier
      run_cycle(-512, "R2");
      check("R2 first bit", longint'(bit_w), 1);
      run_cycle(0, "R2");
      check("R2 neg sample", longint'(bit_w), 0);
      do_reset();
      run_cycle(511, "R2");
      check("R2 first bit", longint'(bit_w), 1);
      run_cycle(0, "R2");
      check("R2 pos sample", longint'(bit_w), 1);

      // Dirty the state, then R1: after reset the stream restarts from zero
      lfsr = 16'hACE1;
      for (int i = 0; i < 100; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         run_cycle(int'($signed(lfsr[9:0])), "R6");
      end
      do_reset();
      for (int i = 0; i < 64; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         run_cycle(int'($signed(lfsr[9:0])), "R1");
      end

      // Sweep of every input code held constant; large ones overload (R5)
      for (int c = -512; c < 512; c++) begin
         for (int k = 0; k < 40; k++) begin
            if (c > 300 || c < -300) run_cycle(c, "R5");
            else                     run_cycle(c, "R6");
         end
      end

      // Ramp across the range: quantizer sign decisions (R3)
      for (int i = 0; i < 2048; i++) begin
         run_cycle((i % 1024) - 512, "R3");
      end

      // Alternating signs of growing size: error extraction (R4)
      for (int i = 0; i < 2048; i++) begin
         run_cycle(((i & 1) != 0) ? (i % 512) : -(i % 512), "R4");
      end

      // Pseudo-random full-range input
      for (int i = 0; i < 8000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         run_cycle(int'($signed(lfsr[9:0])), "R6");
      end

      // R7: long-run mean of the stream tracks a mid-range constant
      foreach (dc_set[j]) begin
         int ones;
         int diff;
         ones = 0;
         for (int k = 0; k < 128; k++) run_cycle(dc_set[j], "R7");
         for (int k = 0; k < 512; k++) begin
            run_cycle(dc_set[j], "R7");
            if (bit_w) ones++;
         end
         diff = (2 * ones - 512) - dc_set[j];
         checks++;
         if (diff > 154 || diff < -154) begin
            errors++;
            $display("FAIL R7 mean actual %0d expected %0d", 2 * ones - 512, dc_set[j]);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   int dc_set [7] = '{-200, -120, -60, 0, 60, 120, 200};

endmodule